// File: doc/BRIEF.md
# Multi-Input Clock Frequency Monitor

This block measures how far each of several input clocks sits from its nominal rate. Every input and both candidate reference clocks are brought into the system clock domain through synchronizers. A gate timer counts rising edges of the chosen reference. Each time it has seen a fixed number of them, one measurement window closes. Within each window every channel counts the rising edges of its own input and subtracts a nominal count. The result is a signed offset, held in units of a programmable ppm scale factor.

At the close of each window a channel compares the magnitude of its offset, in ppm, with a programmable threshold and sets or clears its hard alarm. Inputs marked as low-rate also pass through an edge-interval monitor. That monitor disqualifies the input when the spacing between two rising edges leaves a ±5% band around the expected period. A channel is offered for clock selection only while it is free of both conditions. A channel-select field returns the stored offset of one input.

Top module: `clk_freq_watch`

## Requirements
- R1: With `ref_sel_i` = 0 the measurement window is GATE_REF rising edges of `ref_mst_i`; with `ref_sel_i` = 1 it is GATE_REF rising edges of `ref_dpll_i`.
- R2: At the close of each window a channel stores (input rising edges counted in that window − NOM_CNT) as an 8-bit two's-complement value. The value saturates at +127 and −128.
- R3: `rd_val_o` shows the stored offset of the channel whose index is on `rd_sel_i`; an index of NUM_IN or above reads 0.
- R4: The threshold in ppm is (`thr_code_i` + 1) × `scale_i`. The offset in ppm is |offset| × `scale_i`.
- R5: With `hard_en_i` = 1, at each window close a channel's alarm is set when its offset ppm is above the threshold, cleared when below, and left as it was when equal. Between window closes it does not change.
- R6: With `hard_en_i` = 0 every alarm is cleared at the next window close and never set.
- R7: `qual_o[i]` is 0 whenever `alarm_o[i]` is 1 or channel i's edge flag is set, and 1 otherwise.
- R8: For a channel selected in LOWRATE_MASK, each rising edge after the first one since reset is judged by its interval from the previous edge, in system clock cycles. Outside EDGE_PER ± EDGE_PER/20 (limits included as inside), the interval sets the edge flag; inside, it clears the flag.
- R9: With `noise_en_i` = 0 the edge flag is cleared. Channels not in LOWRATE_MASK never carry an edge flag.
- R10: Reset clears every offset, alarm and edge flag, so `rd_val_o` is 0, `alarm_o` is 0 and `qual_o` is all ones.
- R11: Each channel's offset and alarm depend only on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_mst_i | input | 1 | Master reference clock |
| ref_dpll_i | input | 1 | Reference clock taken from the main DPLL output |
| ref_sel_i | input | 1 | Reference choice: 0 master, 1 DPLL |
| clk_in_i | input | NUM_IN | Monitored input clocks |
| hard_en_i | input | 1 | Hard alarm enable |
| thr_code_i | input | 4 | Threshold code |
| scale_i | input | 4 | ppm per offset unit |
| noise_en_i | input | 1 | Edge-interval monitor enable |
| rd_sel_i | input | 4 | Readback channel index |
| rd_val_o | output | 8 | Offset of the selected channel, two's complement |
| alarm_o | output | NUM_IN | Hard alarm per channel |
| qual_o | output | NUM_IN | Channel qualified for selection |

## Verification
The bench builds the block with four channels, GATE_REF = NOM_CNT = 90 and EDGE_PER = 200, and marks only channel 3 as low-rate. With a reference period of 8 cycles the window is 720 cycles long. Integer input periods of 2, 3, 6, 8, 9, 12 and 16 cycles then give exact offsets of +270, +150, +30, 0, −10, −30 and −45, and a stopped input gives −90. This reaches positive saturation, the exact-equality hysteresis step and the doubled window of the slower DPLL reference. An edge period of 200 cycles gives a tolerance of 10, so the intervals 189, 190, 210 and 211 fall on both sides of both band limits.

// File: rtl/cfm_pkg.sv
// Shared types and helpers for the clock frequency monitor.
// Assumes offsets are always carried as 8-bit two's-complement values.
package cfm_pkg;
    localparam int OFF_W = 8;
    typedef logic signed [OFF_W-1:0] off_t;

    // Clamp a wide signed difference into the 8-bit offset range.
    function automatic off_t sat_off(input logic signed [31:0] d);
        if (d > 32'sd127)
            return 8'sd127;
        else if (d < -32'sd128)
            return -8'sd128;
        else
            return off_t'(d[OFF_W-1:0]);
    endfunction
endpackage

// File: rtl/cfm_sync_rise.sv
// Two-flop synchronizer plus rising-edge detector for W independent bits.
// Assumes each input bit stays high and low for at least one clk period.
module cfm_sync_rise #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    // Move the raw levels into the clk domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/cfm_gate_timer.sv
// Counts rising edges of the selected reference and pulses gate_end_o for
// one cycle after every GATE_REF-th edge. Assumes GATE_REF >= 2.
module cfm_gate_timer #(
    parameter int GATE_REF = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_mst_i,
    input  logic ref_dpll_i,
    input  logic ref_sel_i,
    output logic gate_end_o
);
    localparam int GC_W = $clog2(GATE_REF);

    logic [1:0]      ref_rise;
    logic            tick;
    logic [GC_W-1:0] cnt_q;

    cfm_sync_rise #(.W(2)) u_ref_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({ref_dpll_i, ref_mst_i}),
        .rise_o (ref_rise)
    );

    assign tick = ref_sel_i ? ref_rise[1] : ref_rise[0];

    // Advance the reference edge count and flag the close of each window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            gate_end_o <= 1'b0;
        end else begin
            gate_end_o <= 1'b0;
            if (tick) begin
                if (cnt_q == GC_W'(GATE_REF - 1)) begin
                    cnt_q      <= '0;
                    gate_end_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R1: the edge count never passes the window length
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= GC_W'(GATE_REF - 1));

    // R1: a window close is a single-cycle pulse
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end_o |=> !gate_end_o);
endmodule

// File: rtl/cfm_chan_meter.sv
// One channel: counts input rising edges per window, stores the saturated
// offset against NOM_CNT and runs the hard alarm with hold-on-equal.
// Assumes rise_i is a single-cycle pulse in the clk domain.
module cfm_chan_meter
    import cfm_pkg::*;
#(
    parameter int NOM_CNT = 1000,
    parameter int CNT_W   = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       gate_end_i,
    input  logic       hard_en_i,
    input  logic [3:0] thr_code_i,
    input  logic [3:0] scale_i,
    output logic [7:0] off_o,
    output logic       alarm_o
);
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W:0]     total;
    logic signed [31:0] diff;
    off_t               off_now, off_q;
    logic [8:0]         mag;
    logic [12:0]        ppm, thr;
    logic               alarm_q;

    // Form the offset, its magnitude and both ppm values for this window.
    always_comb begin
        total   = {1'b0, cnt_q} + (CNT_W+1)'(rise_i);
        diff    = $signed({{(31-CNT_W){1'b0}}, total}) - NOM_CNT;
        off_now = sat_off(diff);
        mag     = off_now[7] ? (9'd0 - {1'b1, off_now}) : {1'b0, off_now};
        ppm     = 13'(mag) * 13'(scale_i);
        thr     = 13'(5'(thr_code_i) + 5'd1) * 13'(scale_i);
    end

    // Count edges, latch the offset and update the alarm at each window close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            off_q   <= '0;
            alarm_q <= 1'b0;
        end else if (gate_end_i) begin
            cnt_q <= '0;
            off_q <= off_now;
            if (!hard_en_i)
                alarm_q <= 1'b0;
            else if (ppm > thr)
                alarm_q <= 1'b1;
            else if (ppm < thr)
                alarm_q <= 1'b0;
        end else if (rise_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign off_o   = off_q;
    assign alarm_o = alarm_q;

    // R6: a disabled alarm is low after a window close
    a_r6_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_end_i && !hard_en_i) |=> !alarm_q);

    // R5: the alarm moves only at a window close
    a_r5_gate_only: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end_i |=> $stable(alarm_q));

    // R2: the stored offset moves only at a window close
    a_r2_off_gate_only: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_end_i |=> $stable(off_q));
endmodule

// File: rtl/cfm_edge_window.sv
// Edge-interval check for a low-rate input: every edge after the first is
// judged against EDGE_PER +/- EDGE_PER/20 clk cycles. Assumes EDGE_PER >= 20.
module cfm_edge_window #(
    parameter int EDGE_PER = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic noise_en_i,
    output logic bad_o
);
    localparam int TOL  = EDGE_PER / 20;
    localparam int LO   = EDGE_PER - TOL;
    localparam int HI   = EDGE_PER + TOL;
    localparam int IV_W = $clog2(HI + 2) + 1;

    logic [IV_W-1:0] cnt_q;
    logic [IV_W:0]   ivl;
    logic            seen_q, bad_q;

    assign ivl = {1'b0, cnt_q} + (IV_W+1)'(1);

    // Time the gap between edges and judge it against the band.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            if (rise_i) begin
                cnt_q  <= '0;
                seen_q <= 1'b1;
            end else if (cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (!noise_en_i)
                bad_q <= 1'b0;
            else if (rise_i && seen_q)
                bad_q <= (ivl < (IV_W+1)'(LO)) || (ivl > (IV_W+1)'(HI));
        end
    end

    assign bad_o = bad_q;

    // R9: with the monitor off the flag is cleared
    a_r9_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !noise_en_i |=> !bad_q);

    // R8: the flag changes only on an input edge
    a_r8_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (noise_en_i && !rise_i) |=> $stable(bad_q));
endmodule

// File: rtl/clk_freq_watch.sv
// Top of the multi-input frequency monitor: syncs the inputs, shares one
// gate timer, runs one meter per channel, adds the edge check on low-rate
// channels and muxes one offset out. Assumes NUM_IN <= 16.
module clk_freq_watch #(
    parameter int                NUM_IN       = 14,
    parameter int                GATE_REF     = 1000,
    parameter int                NOM_CNT      = 1000,
    parameter int                EDGE_PER     = 12500,
    parameter logic [NUM_IN-1:0] LOWRATE_MASK = NUM_IN'(3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_mst_i,
    input  logic              ref_dpll_i,
    input  logic              ref_sel_i,
    input  logic [NUM_IN-1:0] clk_in_i,
    input  logic              hard_en_i,
    input  logic [3:0]        thr_code_i,
    input  logic [3:0]        scale_i,
    input  logic              noise_en_i,
    input  logic [3:0]        rd_sel_i,
    output logic [7:0]        rd_val_o,
    output logic [NUM_IN-1:0] alarm_o,
    output logic [NUM_IN-1:0] qual_o
);
    localparam int CNT_W = $clog2(NOM_CNT + 129) + 1;

    logic [NUM_IN-1:0] in_rise;
    logic [NUM_IN-1:0] bad_w;
    logic [7:0]        off_w [NUM_IN];
    logic              gate_end;

    cfm_sync_rise #(.W(NUM_IN)) u_in_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (clk_in_i),
        .rise_o (in_rise)
    );

    cfm_gate_timer #(.GATE_REF(GATE_REF)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_mst_i  (ref_mst_i),
        .ref_dpll_i (ref_dpll_i),
        .ref_sel_i  (ref_sel_i),
        .gate_end_o (gate_end)
    );

    for (genvar g = 0; g < NUM_IN; g++) begin : g_ch
        cfm_chan_meter #(.NOM_CNT(NOM_CNT), .CNT_W(CNT_W)) u_meter (
            .clk        (clk),
            .rst_n      (rst_n),
            .rise_i     (in_rise[g]),
            .gate_end_i (gate_end),
            .hard_en_i  (hard_en_i),
            .thr_code_i (thr_code_i),
            .scale_i    (scale_i),
            .off_o      (off_w[g]),
            .alarm_o    (alarm_o[g])
        );

        if (LOWRATE_MASK[g]) begin : g_low
            cfm_edge_window #(.EDGE_PER(EDGE_PER)) u_win (
                .clk        (clk),
                .rst_n      (rst_n),
                .rise_i     (in_rise[g]),
                .noise_en_i (noise_en_i),
                .bad_o      (bad_w[g])
            );
        end else begin : g_fast
            assign bad_w[g] = 1'b0;
        end
    end

    assign qual_o = ~(alarm_o | bad_w);

    // Return the offset of the selected channel, zero when out of range.
    always_comb begin
        rd_val_o = '0;
        for (int i = 0; i < NUM_IN; i++)
            if (rd_sel_i == 4'(i))
                rd_val_o = off_w[i];
    end
endmodule

// File: tb/tb_clk_freq_watch.sv
// Bench: a vector table for offset and alarm behaviour, then directed tests
// for readback range, channel independence, edge window and reset.
module tb_clk_freq_watch;
    localparam int NI = 4;
    localparam int NV = 14;
    localparam int SETTLE = 4400;

    // stimulus: input-0 period, ref select, enable, code, scale
    localparam int V_PER  [NV] = '{8, 9, 9, 9, 9, 9, 6, 6, 3, 2, 0, 16, 8, 16};
    localparam int V_SEL  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam int V_EN   [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1, 1, 1, 1};
    localparam int V_CODE [NV] = '{0, 10, 9, 8, 9, 10, 15, 15, 15, 15, 15, 2, 15, 15};
    localparam int V_SCL  [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 8, 8, 15, 15, 1, 1};
    // expected offset (8-bit pattern) and alarm on channel 0
    localparam int V_OFF  [NV] = '{0, 246, 246, 246, 246, 246, 30, 30, 127, 127, 166, 211, 90, 0};
    localparam int V_ALM  [NV] = '{0, 0, 0, 1, 1, 0, 1, 0, 1, 1, 1, 1, 1, 0};
    localparam string V_REQ [NV] = '{"R2", "R4", "R5", "R5", "R5", "R5", "R4", "R6",
                                     "R2", "R2", "R2", "R4", "R1", "R1"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_mst = 1'b0, ref_dpll = 1'b0, ref_sel = 1'b0;
    logic [NI-1:0] cin = '0;
    logic hard_en = 1'b0, noise_en = 1'b0;
    logic [3:0] thr_code = '0, scale = '0, rd_sel = '0;
    logic [7:0] rd_val;
    logic [NI-1:0] alarm, qual;

    int per [NI] = '{8, 8, 8, 200};
    int gc  [NI] = '{0, 0, 0, 0};
    int rmc = 0, rdc = 0;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    clk_freq_watch #(
        .NUM_IN(NI), .GATE_REF(90), .NOM_CNT(90), .EDGE_PER(200),
        .LOWRATE_MASK(4'b1000)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_mst_i(ref_mst), .ref_dpll_i(ref_dpll),
        .ref_sel_i(ref_sel), .clk_in_i(cin), .hard_en_i(hard_en),
        .thr_code_i(thr_code), .scale_i(scale), .noise_en_i(noise_en),
        .rd_sel_i(rd_sel), .rd_val_o(rd_val), .alarm_o(alarm), .qual_o(qual)
    );

    // Input clock generators: period per[i] cycles, 0 means stopped.
    always @(posedge clk) begin
        for (int i = 0; i < NI; i++) begin
            if (per[i] == 0) begin
                gc[i]  <= 0;
                cin[i] <= 1'b0;
            end else begin
                gc[i]  <= (gc[i] + 1 >= per[i]) ? 0 : gc[i] + 1;
                cin[i] <= (gc[i] < per[i] / 2);
            end
        end
        rmc      <= (rmc + 1 >= 8) ? 0 : rmc + 1;
        ref_mst  <= (rmc < 4);
        rdc      <= (rdc + 1 >= 16) ? 0 : rdc + 1;
        ref_dpll <= (rdc < 8);
    end

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5ns * 190000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R10: state right after reset
        wait_cyc(10);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R10 rd_val", int'(rd_val), 0);
        chk("R10 alarm", int'(alarm), 0);
        chk("R10 qual", int'(qual), 15);

        // Vector table on channel 0
        for (int k = 0; k < NV; k++) begin
            per[0]   = V_PER[k];
            ref_sel  = V_SEL[k][0];
            hard_en  = V_EN[k][0];
            thr_code = 4'(V_CODE[k]);
            scale    = 4'(V_SCL[k]);
            rd_sel   = 4'd0;
            wait_cyc(SETTLE);
            chk({V_REQ[k], " offset"}, int'(rd_val), V_OFF[k]);
            chk({V_REQ[k], " alarm"}, int'(alarm[0]), V_ALM[k]);
            chk("R7 qual follows alarm", int'(qual[0]), 1 - V_ALM[k]);
        end

        // R3: out-of-range indices read zero
        rd_sel = 4'd4;
        wait_cyc(1);
        chk("R3 sel4", int'(rd_val), 0);
        rd_sel = 4'd15;
        wait_cyc(1);
        chk("R3 sel15", int'(rd_val), 0);

        // R11: channels measured independently
        ref_sel = 1'b0; hard_en = 1'b1; thr_code = 4'd15; scale = 4'd1;
        per[0] = 8; per[1] = 4; per[2] = 12;
        wait_cyc(SETTLE);
        rd_sel = 4'd1;
        wait_cyc(1);
        chk("R11 ch1 offset", int'(rd_val), 90);
        rd_sel = 4'd2;
        wait_cyc(1);
        chk("R11 ch2 offset", int'(rd_val), 226);
        chk("R11 alarms", int'(alarm[2:0]), 6);

        // R8 / R9: edge window on channel 3 (alarms disabled)
        hard_en = 1'b0; noise_en = 1'b1; per[3] = 200;
        wait_cyc(SETTLE);
        chk("R8 nominal qual", int'(qual[3]), 1);
        chk("R9 fast channel unaffected", int'(qual[1]), 1);
        per[3] = 211;
        wait_cyc(1500);
        chk("R8 above band", int'(qual[3]), 0);
        per[3] = 210;
        wait_cyc(1500);
        chk("R8 upper limit", int'(qual[3]), 1);
        per[3] = 189;
        wait_cyc(1500);
        chk("R8 below band", int'(qual[3]), 0);
        per[3] = 190;
        wait_cyc(1500);
        chk("R8 lower limit", int'(qual[3]), 1);
        per[3] = 211;
        noise_en = 1'b0;
        wait_cyc(1500);
        chk("R9 monitor off", int'(qual[3]), 1);

        // R10: reset in mid-run clears alarms, offsets and edge flags
        noise_en = 1'b1; hard_en = 1'b1;
        wait_cyc(1500);
        chk("R10 pre-reset alarm", int'(alarm[1]), 1);
        chk("R10 pre-reset edge flag", int'(qual[3]), 0);
        rst_n = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        rd_sel = 4'd1;
        wait_cyc(3);
        chk("R10 alarm cleared", int'(alarm), 0);
        chk("R10 offset cleared", int'(rd_val), 0);
        chk("R10 qual restored", int'(qual), 15);

        finish_run();
    end
endmodule